// File: doc/BRIEF.md
# Serial Channel Status and Interrupt Logic

This block keeps the status flags of one asynchronous serial channel and turns them into receive and transmit interrupt requests. The receiver reports each finished frame, and any overrun, parity or stop-bit fault, as one-clock pulses. The transmit side sees CPU writes to the transmit holding register and a one-clock load strobe from the shift register. The CPU clears the error flags by writing 0 to an error-reset bit, and it sets three control bits: receive interrupt enable, clear-to-send enable and transmit interrupt enable.

Modem and stop-mode inputs override the flags directly. While the synchronized carrier-detect input is high, all three error flags are held clear. A rising edge of carrier detect latches a pending interrupt, and a status read clears it. While the shared pin serves as clear-to-send and is high, the transmit-empty flag reads 0 and the shifter cannot take a byte. The I/O stop input empties the channel: it clears the receive and error flags and forces transmit-empty to 1.

Top module: `serial_status_irq`

## Requirements
- R1: A pulse on rx_stop_bad, rx_parity_bad or rx_overrun sets frame_err, parity_err or overrun at the next clock edge, unless a clear condition holds in that cycle.
- R2: The three error flags clear at the next edge when efr_write is high with efr_value 0, when the synchronized carrier is high, or when io_stop is high. A clear wins over a set in the same cycle, and writing efr_value 1 has no effect.
- R3: rx_done sets rx_full and rx_taken clears it. If both occur in the same cycle, rx_done wins.
- R4: tx_write makes tx_empty 0. A tx_load while the register is not empty and clear-to-send does not block makes it 1. A tx_write in the same cycle as a tx_load leaves it 0.
- R5: io_stop clears rx_full and the error flags and sets the transmit-empty state to 1 at the next edge.
- R6: While cts_en is 1 and share_pin is 1, tx_empty reads 0 and tx_load is ignored. The stored state is kept and shows again when the pin falls.
- R7: With cts_en 1, csio_rxd is held at 1. With cts_en 0, csio_rxd follows share_pin.
- R8: When CARRIER_IRQ is 1, a rising edge on carrier_in sets carrier_pend after SYNC_STAGES+1 clock edges. A status_read clears it, and a new edge in the same cycle wins.
- R9: rx_irq is 1 when rx_ie is 1 and at least one of rx_full, overrun, parity_err, frame_err or carrier_pend is 1.
- R10: tx_irq is 1 when tx_ie is 1 and tx_empty is 1.
- R11: After reset, tx_empty is 1 and every other flag, control bit and interrupt output is 0.
- R12: ctrl_write loads ctrl_rx_ie, ctrl_cts_en and ctrl_tx_ie into rx_ie, cts_en and tx_ie. The flags are read-only and have no write path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_done | input | 1 | Receiver finished a frame (pulse) |
| rx_overrun | input | 1 | Receiver overrun (pulse) |
| rx_parity_bad | input | 1 | Parity fault (pulse) |
| rx_stop_bad | input | 1 | Stop bit sampled as 0 (pulse) |
| rx_taken | input | 1 | CPU read of receive data |
| tx_write | input | 1 | CPU write of transmit holding register |
| tx_load | input | 1 | Shift register load strobe |
| efr_write | input | 1 | CPU write of error-reset bit |
| efr_value | input | 1 | Value written to error-reset bit |
| ctrl_write | input | 1 | CPU write of control bits |
| ctrl_rx_ie | input | 1 | Receive interrupt enable write data |
| ctrl_cts_en | input | 1 | Clear-to-send enable write data |
| ctrl_tx_ie | input | 1 | Transmit interrupt enable write data |
| status_read | input | 1 | CPU read of status |
| carrier_in | input | 1 | Asynchronous carrier-detect input |
| share_pin | input | 1 | Shared clear-to-send / clocked-serial receive pin |
| io_stop | input | 1 | I/O stop mode |
| rx_full | output | 1 | Receive data present |
| overrun | output | 1 | Overrun flag |
| parity_err | output | 1 | Parity error flag |
| frame_err | output | 1 | Stop-bit error flag |
| tx_empty | output | 1 | Transmit register empty flag |
| rx_ie | output | 1 | Receive interrupt enable |
| cts_en | output | 1 | Clear-to-send enable |
| tx_ie | output | 1 | Transmit interrupt enable |
| carrier_pend | output | 1 | Carrier rising edge pending |
| csio_rxd | output | 1 | Receive data to clocked serial port |
| rx_irq | output | 1 | Receive interrupt request |
| tx_irq | output | 1 | Transmit interrupt request |

## Verification
The assertions assume that the receiver and shifter strobes are synchronous to clk and last one cycle, and that carrier_in is the only asynchronous input. The stimulus changes every input on the falling edge and holds each strobe for exactly one cycle. Carrier edges are spaced at least SYNC_STAGES+2 cycles apart, so every edge passes the synchronizer before a status read that could clear it.

// File: rtl/serial_status_irq.sv
module serial_status_irq #(
  parameter int SYNC_STAGES = 2,
  parameter bit CARRIER_IRQ = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_done,
  input  logic rx_overrun,
  input  logic rx_parity_bad,
  input  logic rx_stop_bad,
  input  logic rx_taken,
  input  logic tx_write,
  input  logic tx_load,
  input  logic efr_write,
  input  logic efr_value,
  input  logic ctrl_write,
  input  logic ctrl_rx_ie,
  input  logic ctrl_cts_en,
  input  logic ctrl_tx_ie,
  input  logic status_read,
  input  logic carrier_in,
  input  logic share_pin,
  input  logic io_stop,
  output logic rx_full,
  output logic overrun,
  output logic parity_err,
  output logic frame_err,
  output logic tx_empty,
  output logic rx_ie,
  output logic cts_en,
  output logic tx_ie,
  output logic carrier_pend,
  output logic csio_rxd,
  output logic rx_irq,
  output logic tx_irq
);

  logic [SYNC_STAGES-1:0] car_sync;
  logic car_s, car_d, car_rise;
  logic err_clr, cts_blk, load_ok, tdre_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      car_sync <= '0;
      car_d    <= 1'b0;
    end else begin
      car_sync <= {car_sync[SYNC_STAGES-2:0], carrier_in};
      car_d    <= car_s;
    end

  assign car_s    = car_sync[SYNC_STAGES-1];
  assign car_rise = car_s & ~car_d;
  assign err_clr  = (efr_write & ~efr_value) | car_s | io_stop;
  assign cts_blk  = cts_en & share_pin;
  assign load_ok  = tx_load & ~tdre_q & ~cts_blk;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      overrun    <= 1'b0;
      parity_err <= 1'b0;
      frame_err  <= 1'b0;
    end else if (err_clr) begin
      overrun    <= 1'b0;
      parity_err <= 1'b0;
      frame_err  <= 1'b0;
    end else begin
      overrun    <= overrun    | rx_overrun;
      parity_err <= parity_err | rx_parity_bad;
      frame_err  <= frame_err  | rx_stop_bad;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          rx_full <= 1'b0;
    else if (io_stop)    rx_full <= 1'b0;
    else if (rx_done)    rx_full <= 1'b1;
    else if (rx_taken)   rx_full <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          tdre_q <= 1'b1;
    else if (io_stop)    tdre_q <= 1'b1;
    else if (tx_write)   tdre_q <= 1'b0;
    else if (load_ok)    tdre_q <= 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_ie  <= 1'b0;
      cts_en <= 1'b0;
      tx_ie  <= 1'b0;
    end else if (ctrl_write) begin
      rx_ie  <= ctrl_rx_ie;
      cts_en <= ctrl_cts_en;
      tx_ie  <= ctrl_tx_ie;
    end

  generate
    if (CARRIER_IRQ) begin : g_car_irq
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)           carrier_pend <= 1'b0;
        else if (car_rise)    carrier_pend <= 1'b1;
        else if (status_read) carrier_pend <= 1'b0;
    end else begin : g_no_car_irq
      assign carrier_pend = 1'b0;
    end
  endgenerate

  assign tx_empty = tdre_q & ~cts_blk;
  assign csio_rxd = cts_en ? 1'b1 : share_pin;
  assign rx_irq   = rx_ie & (rx_full | overrun | parity_err | frame_err | carrier_pend);
  assign tx_irq   = tx_ie & tx_empty;

  p_stop_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_stop_bad && !err_clr) |=> frame_err);

  p_clear_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (efr_write && !efr_value) |=> (!frame_err && !parity_err && !overrun));

  p_write_empties_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_write && !io_stop) |=> !tdre_q);

  p_stop_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
    io_stop |=> (tdre_q && !rx_full && !frame_err));

  p_cts_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cts_blk && !io_stop && !tx_write) |=> $stable(tdre_q));

  p_read_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (status_read && !car_rise) |=> !carrier_pend);

endmodule

// File: tb/tb_serial_status_irq.sv
module tb_serial_status_irq;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_done = 0, rx_overrun = 0, rx_parity_bad = 0, rx_stop_bad = 0, rx_taken = 0;
  logic tx_write = 0, tx_load = 0, efr_write = 0, efr_value = 0;
  logic ctrl_write = 0, ctrl_rx_ie = 0, ctrl_cts_en = 0, ctrl_tx_ie = 0;
  logic status_read = 0, carrier_in = 0, share_pin = 0, io_stop = 0;
  logic rx_full, overrun, parity_err, frame_err, tx_empty, rx_ie, cts_en, tx_ie;
  logic carrier_pend, csio_rxd, rx_irq, tx_irq;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_status_irq dut (.*);

  // inputs {rx_done, ovr, par, stop, taken, txw, txl, efrw, efrv}, expect {rxf, ov, pe, fe, te}
  localparam logic [13:0] VEC [14] = '{
    {9'b000100000, 5'b00011}, {9'b001000000, 5'b00111},
    {9'b000000011, 5'b00111}, {9'b000000010, 5'b00001},
    {9'b010100010, 5'b00001}, {9'b100000000, 5'b10001},
    {9'b000001000, 5'b10000}, {9'b000000100, 5'b10001},
    {9'b000001100, 5'b10000}, {9'b000000100, 5'b10001},
    {9'b000000100, 5'b10001}, {9'b010000000, 5'b11001},
    {9'b000010000, 5'b01001}, {9'b100010000, 5'b11001}};

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic clr_in();
    {rx_done, rx_overrun, rx_parity_bad, rx_stop_bad, rx_taken} = '0;
    {tx_write, tx_load, efr_write, efr_value, ctrl_write, status_read, io_stop} = '0;
  endtask

  task automatic ctrl(logic rie, logic cen, logic tie);
    ctrl_write = 1; ctrl_rx_ie = rie; ctrl_cts_en = cen; ctrl_tx_ie = tie;
    cyc(); ctrl_write = 0;
  endtask

  initial begin
    repeat (CLK_PERIOD * 20000) #1;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    cyc(2); rst_n = 1; cyc();
    chk("R11 flags", {rx_full, overrun, parity_err, frame_err, tx_empty}, 8'b00001);
    chk("R11 ctrl/irq", {rx_ie, cts_en, tx_ie, carrier_pend, rx_irq, tx_irq}, 8'b0);
    chk("R10 tx_irq masked", tx_irq, 0);

    ctrl(1, 0, 1);
    chk("R12 ctrl readback", {rx_ie, cts_en, tx_ie}, 8'b101);

    foreach (VEC[i]) begin
      {rx_done, rx_overrun, rx_parity_bad, rx_stop_bad, rx_taken,
       tx_write, tx_load, efr_write, efr_value} = VEC[i][13:5];
      cyc(); clr_in();
      chk($sformatf("R1 R2 R3 R4 vec%0d", i),
          {rx_full, overrun, parity_err, frame_err, tx_empty}, VEC[i][4:0]);
      chk($sformatf("R9 rx_irq vec%0d", i), rx_irq, |VEC[i][4:1]);
      chk($sformatf("R10 tx_irq vec%0d", i), tx_irq, VEC[i][0]);
    end

    tx_write = 1; rx_done = 1; cyc(); clr_in();
    io_stop = 1; rx_stop_bad = 1; cyc(); clr_in();
    chk("R5 stop mode", {rx_full, overrun, frame_err, tx_empty}, 8'b0001);

    ctrl(1, 1, 1);
    chk("R7 csio_rxd held", csio_rxd, 1);
    tx_write = 1; cyc(); clr_in();
    share_pin = 1; tx_load = 1; cyc(); clr_in();
    chk("R6 blocked", {tx_empty, tx_irq}, 8'b00);
    share_pin = 0; #1;
    chk("R6 state kept", tx_empty, 0);
    tx_load = 1; cyc(); clr_in();
    chk("R6 load after release", tx_empty, 1);
    share_pin = 1; #1;
    chk("R6 held low", tx_empty, 0);
    ctrl(1, 0, 1);
    chk("R6 disabled", tx_empty, 1);
    share_pin = 0; #1;
    chk("R7 csio_rxd follows 0", csio_rxd, 0);
    share_pin = 1; #1;
    chk("R7 csio_rxd follows 1", csio_rxd, 1);
    share_pin = 0;

    rx_stop_bad = 1; cyc(); clr_in();
    chk("R1 frame set", frame_err, 1);
    carrier_in = 1; cyc(2);
    chk("R8 not yet", carrier_pend, 0);
    cyc(2);
    chk("R2 carrier clears", frame_err, 0);
    chk("R8 pending", carrier_pend, 1);
    chk("R9 carrier irq", rx_irq, 1);
    rx_stop_bad = 1; rx_parity_bad = 1; cyc(); clr_in();
    chk("R2 held clear", {parity_err, frame_err}, 0);
    status_read = 1; cyc(); clr_in();
    chk("R8 read clears", carrier_pend, 0);
    chk("R9 irq drops", rx_irq, 0);
    carrier_in = 0; cyc(4);

    rx_overrun = 1; cyc(); clr_in();
    ctrl(0, 0, 0);
    chk("R9 masked", rx_irq, 0);
    chk("R10 masked", tx_irq, 0);
    chk("R12 ctrl cleared", {rx_ie, cts_en, tx_ie}, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule